// File: doc/BRIEF.md
# Flag Threshold Register Sequencer

This block keeps the two threshold values a FIFO's programmable flag logic compares against: the almost-empty offset and the almost-full offset. A host reaches both without any address lines. It holds a single active-low load strobe and pulses the write or read enable of the FIFO. A selector then steps between the two registers automatically, visiting the almost-empty register first, then the almost-full register, then the almost-empty register again.

Values enter through the low bits of the FIFO write data bus on the write clock. They come back on the read data bus on the read clock. The write side and the readback side each keep their own selector, so a host can program the pair and then audit it from the read port. When load is high the FIFO ports carry ordinary traffic, and this block neither changes state nor moves a selector.

Both registers reset to a default that depends on the FIFO depth. The two offsets are driven to the flag logic at all times.

Top module: `offs_prog_seq`

## Requirements
- R1: While `load_n`=0 and `wr_en_n`=0, every rising `wr_clk` edge stores `ofs_din` in the register the write selector points at. The first such edge after reset writes the almost-empty register, the second writes the almost-full register, and the third wraps back to almost-empty.
- R2: While `load_n`=0 and `wr_en_n`=1, a `wr_clk` edge changes neither register and does not advance the write selector.
- R3: While `load_n`=0 and `rd_en_n`=0, every rising `rd_clk` edge places the selected register on `rdbk_data[11:0]`. The read selector visits almost-empty, then almost-full, then wraps.
- R4: While `load_n`=1, neither enable changes a register, advances a selector, or changes `rdbk_data`.
- R5: A host may abandon a sequence part way by raising `load_n`. The next load access continues with the register that follows the last one accessed.
- R6: Reset (`rst_n`=0, asynchronous) sets both registers to 31 when DEPTH ≤ 256, to 63 when DEPTH ≤ 512, and to 127 otherwise. It clears `rdbk_data` to zero and points both selectors at almost-empty.
- R7: `rdbk_data` bits above bit 11 are always zero.
- R8: The read selector and the write selector advance independently. Writes do not move the read selector, and readbacks do not move the write selector.
- R9: `rdbk_data` holds its value on every `rd_clk` edge that is not a readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low threshold access strobe |
| wr_en_n | input | 1 | Active-low FIFO write enable |
| rd_en_n | input | 1 | Active-low FIFO read enable |
| ofs_din | input | 12 | Low bits of the FIFO write data bus |
| ae_offset | output | 12 | Almost-empty threshold to the flag logic |
| af_offset | output | 12 | Almost-full threshold to the flag logic |
| rdbk_data | output | 18 | Readback word on the FIFO read data bus |

## Verification
The hardest case to reach is a pair of selectors that sit on different registers. The ports never show a selector's position directly, so the bench infers it from where the next write lands or from which value the next readback returns. The stimulus gets there in three ways. It abandons a write sequence half way, which leaves the write selector on almost-full. It issues an odd number of readbacks. It then interleaves single writes and reads, so that every later access depends on both selectors having kept their own place across idle, no-op and normal-traffic cycles and across a mid-run reset.

// File: rtl/offs_prog_pkg.sv
`timescale 1ns/1ps
package offs_prog_pkg;

  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } offs_sel_e;

  // Reset threshold chosen from the FIFO depth.
  function automatic int unsigned offs_default(input int unsigned depth);
    if (depth <= 256)      return 31;
    else if (depth <= 512) return 63;
    else                   return 127;
  endfunction

  function automatic offs_sel_e offs_next(input offs_sel_e cur);
    return (cur == SEL_AE) ? SEL_AF : SEL_AE;
  endfunction

endpackage

// File: rtl/offs_sel_ptr.sv
`timescale 1ns/1ps
module offs_sel_ptr
  import offs_prog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  output offs_sel_e sel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= SEL_AE;
    else if (step) sel <= offs_next(sel);
  end

  // R1 / R3: each access moves the selector to the other register
  a_r1_sel_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (sel != $past(sel)));

  // R2 / R8: without an access the selector keeps its place
  a_r8_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(sel));

endmodule

// File: rtl/offs_reg_bank.sv
`timescale 1ns/1ps
module offs_reg_bank
  import offs_prog_pkg::*;
#(
  parameter int unsigned OFS_W = 12,
  parameter int unsigned DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  offs_sel_e        sel,
  input  logic [OFS_W-1:0] din,
  output logic [OFS_W-1:0] ae_q,
  output logic [OFS_W-1:0] af_q
);

  localparam int unsigned NREG = 2;
  localparam logic [OFS_W-1:0] DEF_VAL = OFS_W'(offs_default(DEPTH));

  logic [OFS_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_stb && (sel == offs_sel_e'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[g] <= DEF_VAL;
      else if (hit) regs[g] <= din;
    end
  end

  assign ae_q = regs[SEL_AE];
  assign af_q = regs[SEL_AF];

  // R2: no write strobe leaves both thresholds untouched
  a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(ae_q) && $stable(af_q)));

  // R1: a write touches only the selected register
  a_r1_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && sel == SEL_AE) |=> $stable(af_q));

endmodule

// File: rtl/offs_readback.sv
`timescale 1ns/1ps
module offs_readback
  import offs_prog_pkg::*;
#(
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  offs_sel_e         sel,
  input  logic [OFS_W-1:0]  ae_q,
  input  logic [OFS_W-1:0]  af_q,
  output logic [DATA_W-1:0] dout
);

  logic [OFS_W-1:0] picked;
  assign picked = (sel == SEL_AF) ? af_q : ae_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dout <= '0;
    else if (rd_stb) dout <= DATA_W'(picked);
  end

  // R7: nothing ever appears above the threshold field
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dout >> OFS_W) == '0);

  // R9: the readback word holds between readbacks
  a_r9_rdbk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(dout));

endmodule

// File: rtl/offs_prog_seq.sv
`timescale 1ns/1ps
module offs_prog_seq
  import offs_prog_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned DATA_W = 18
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              wr_en_n,
  input  logic              rd_en_n,
  input  logic [OFS_W-1:0]  ofs_din,
  output logic [OFS_W-1:0]  ae_offset,
  output logic [OFS_W-1:0]  af_offset,
  output logic [DATA_W-1:0] rdbk_data
);

  // Named access events, brought out for the checks
  logic      wr_step;
  logic      rd_step;
  offs_sel_e wr_sel;
  offs_sel_e rd_sel;

  assign wr_step = !load_n && !wr_en_n;
  assign rd_step = !load_n && !rd_en_n;

  offs_sel_ptr u_wr_ptr (
    .clk  (wr_clk),
    .rst_n(rst_n),
    .step (wr_step),
    .sel  (wr_sel)
  );

  offs_sel_ptr u_rd_ptr (
    .clk  (rd_clk),
    .rst_n(rst_n),
    .step (rd_step),
    .sel  (rd_sel)
  );

  offs_reg_bank #(.OFS_W(OFS_W), .DEPTH(DEPTH)) u_bank (
    .clk   (wr_clk),
    .rst_n (rst_n),
    .wr_stb(wr_step),
    .sel   (wr_sel),
    .din   (ofs_din),
    .ae_q  (ae_offset),
    .af_q  (af_offset)
  );

  offs_readback #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rdbk (
    .clk   (rd_clk),
    .rst_n (rst_n),
    .rd_stb(rd_step),
    .sel   (rd_sel),
    .ae_q  (ae_offset),
    .af_q  (af_offset),
    .dout  (rdbk_data)
  );

  // R1: a write aimed at almost-empty carries the bus value into it
  a_r1_write_lands: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_step && wr_sel == SEL_AE) |=> (ae_offset == $past(ofs_din)));

  // R4: normal FIFO traffic leaves the thresholds alone
  a_r4_traffic_no_write: assert property (@(posedge wr_clk) disable iff (!rst_n)
    load_n |=> ($stable(ae_offset) && $stable(af_offset)));

  // R4: normal FIFO traffic leaves the readback word alone
  a_r4_traffic_no_rdbk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    load_n |=> $stable(rdbk_data));

endmodule

// File: tb/offs_prog_seq_bench.sv
`timescale 1ns/1ps
module offs_prog_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_n = 1'b1;
  logic        wr_en_n = 1'b1;
  logic        rd_en_n = 1'b1;
  logic [11:0] ofs_din = '0;
  logic [11:0] ae_offset, af_offset, s_ae, s_af;
  logic [17:0] rdbk_data, s_rdbk;

  int vectors = 0;
  int miscompares = 0;

  // behavioural model state
  int m_ae, m_af, m_rdbk, m_wsel, m_rsel;

  always #2 clk = ~clk;  // 250 MHz

  offs_prog_seq u_offs_prog_seq (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
    .load_n(load_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n),
    .ofs_din(ofs_din), .ae_offset(ae_offset), .af_offset(af_offset),
    .rdbk_data(rdbk_data)
  );

  offs_prog_seq #(.DEPTH(256)) u_small (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
    .load_n(1'b1), .wr_en_n(1'b1), .rd_en_n(1'b1),
    .ofs_din(12'h000), .ae_offset(s_ae), .af_offset(s_af),
    .rdbk_data(s_rdbk)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "ae_offset", int'(ae_offset), m_ae);
    chk(tag, "af_offset", int'(af_offset), m_af);
    chk(tag, "rdbk_data", int'(rdbk_data), m_rdbk);
  endtask

  task automatic model_reset();
    m_ae = 127; m_af = 127; m_rdbk = 0; m_wsel = 0; m_rsel = 0;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; load_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1;
    model_reset();
    #1 compare_all(tag);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cyc(input bit ld, input bit we, input bit re,
                     input logic [11:0] d, input string tag);
    @(negedge clk);
    load_n = ld; wr_en_n = we; rd_en_n = re; ofs_din = d;
    @(posedge clk);
    if (!ld && !re) begin
      m_rdbk = (m_rsel == 1) ? m_af : m_ae;
      m_rsel ^= 1;
    end
    if (!ld && !we) begin
      if (m_wsel == 0) m_ae = int'(d); else m_af = int'(d);
      m_wsel ^= 1;
    end
    #1 compare_all(tag);
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    model_reset();
    do_reset("R6");
    // R6: default of the shallow variant
    chk("R6", "small ae", int'(s_ae), 31);
    chk("R6", "small af", int'(s_af), 31);
    chk("R6", "small rdbk", int'(s_rdbk), 0);

    // R1: three writes, wrapping to almost-empty
    cyc(0, 0, 1, 12'hA5A, "R1");
    cyc(0, 0, 1, 12'h123, "R1");
    cyc(0, 0, 1, 12'h0F0, "R1");
    // R2: load low, write enable high, garbage data
    cyc(0, 1, 1, 12'hFFF, "R2");
    cyc(0, 1, 1, 12'h555, "R2");
    // R4: normal traffic with both enables
    cyc(1, 0, 1, 12'hBAD, "R4");
    cyc(1, 1, 0, 12'hBAD, "R4");
    cyc(1, 1, 1, 12'h000, "R4");
    // R3: readback order; R7 upper bits zero via full-width compare
    cyc(0, 1, 0, 12'h000, "R3");
    cyc(0, 1, 0, 12'h000, "R3");
    cyc(0, 1, 0, 12'h000, "R7");
    // R9: idle read side holds readback word
    cyc(0, 1, 1, 12'h000, "R9");
    cyc(1, 1, 1, 12'h000, "R9");
    // R5: write selector now on almost-full; abandon after one write
    cyc(0, 0, 1, 12'h777, "R5");
    cyc(1, 1, 1, 12'h000, "R5");
    cyc(0, 0, 1, 12'h3C3, "R5");
    // R8: read selector sits on almost-full independently
    cyc(0, 1, 0, 12'h000, "R8");
    cyc(0, 0, 1, 12'hFEE, "R8");
    cyc(0, 1, 0, 12'h000, "R8");
    cyc(0, 0, 1, 12'h00D, "R8");
    cyc(0, 1, 0, 12'h000, "R8");
    cyc(0, 1, 0, 12'h000, "R8");
    // R6: mid-run reset returns defaults and both selectors
    do_reset("R6");
    cyc(0, 1, 0, 12'h000, "R6");
    cyc(0, 0, 1, 12'h001, "R6");
    cyc(0, 1, 0, 12'h000, "R6");
    cyc(0, 1, 0, 12'h000, "R6");
    cyc(1, 1, 1, 12'h000, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule